// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block controls the low-power sleep state of a small microcontroller core. A halt request from instruction decode puts the core to sleep. The block then drops the core clock enable and sets the power-down flag. It clears the time-out flag and, depending on the selected watchdog clock source, tells the watchdog counter to restart and keep counting or to stop. The block runs on an always-on slow clock, so it keeps watching for wake events while the core clock is gated off.

The block recognises four wake sources: an external reset request, a watchdog overflow, an interrupt request, and a high-to-low transition on any of eight port pins whose wake-enable bit is set. The winning source is recorded in a one-hot cause register. The core clock enable returns one slow-clock cycle after the wake is recorded. In that same cycle the block issues the reset strobe that matches the cause: a full reset for an external reset, and a program-counter and stack-pointer reset for a watchdog overflow. A pin or interrupt wake issues no strobe, so the core resumes at the instruction after the halt.

Top module: `pdwake_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block takes this state: core clock enabled, not sleeping, `pdf` and `to_flag` low, `wake_cause` zero, both reset strobes low, `wdt_run` high and `wdt_clr` low.
- R2: A `halt_req` seen while running (with no `ext_reset`) makes the next cycle show these values: `sleeping` high, `core_clk_en` low, `pdf` high, `to_flag` low, `wake_cause` zero.
- R3: A `clrwdt_req` seen while running (with no halt and no external reset) makes `pdf` low on the next cycle.
- R4: While asleep, a falling edge on port pin i with `wake_en[i]`=1 wakes the core. After the third clock edge that follows the pin change, `wake_cause` is 4'b0010. No reset strobe is issued.
- R5: While asleep, a falling edge on a pin whose wake-enable bit is 0 does not wake the core, and neither does a rising edge on any pin. `sleeping` stays high and `wake_cause` stays zero.
- R6: While asleep, `irq` wakes the core with `wake_cause` 4'b0100 and no reset strobe.
- R7: While asleep, `wdt_ovf` wakes the core with `wake_cause` 4'b1000. It sets `to_flag` in the cycle the cause is recorded and pulses `pcsp_rst` for one cycle when the clock enable returns. `pdf` stays high.
- R8: While asleep, `ext_reset` wakes the core with `wake_cause` 4'b0001 and pulses `full_rst` for one cycle when the clock enable returns. `pdf` and `to_flag` keep their values.
- R9: When wake sources arrive together, the winner is chosen in this order: external reset, then watchdog, then interrupt, then pin.
- R10: The cause is recorded one cycle after a non-pin wake input is sampled. `core_clk_en` and not-sleeping return exactly one cycle after that.
- R11: At halt entry with `wdt_src_sys`=0, `wdt_clr` pulses for one cycle and `wdt_run` stays high through sleep. With `wdt_src_sys`=1, there is no pulse and `wdt_run` is low during sleep. `wdt_run` is high again once running.
- R12: `wake_cause` never has more than one bit set. It holds its value while running until the next halt entry.
- R13: `ext_reset` while running pulses `full_rst` on the next cycle, and the core stays awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| halt_req | input | 1 | Halt instruction executed (one-cycle pulse) |
| clrwdt_req | input | 1 | Clear-watchdog instruction executed |
| ext_reset | input | 1 | External reset request, synchronous to clk |
| irq | input | 1 | Pending system interrupt |
| wdt_ovf | input | 1 | Watchdog counter overflow |
| wdt_src_sys | input | 1 | 1 when the watchdog is clocked from the system clock |
| port_in | input | 8 | Port pins, asynchronous |
| wake_enable | input | 8 | Per-pin wake enable |
| core_clk_en | output | 1 | Core clock enable |
| sleeping | output | 1 | High from halt entry until clock enable returns |
| wake_cause | output | 4 | One-hot cause: bit0 reset, bit1 pin, bit2 interrupt, bit3 watchdog |
| pcsp_rst | output | 1 | One-cycle program counter and stack pointer reset |
| full_rst | output | 1 | One-cycle full system reset |
| pdf | output | 1 | Power-down flag |
| to_flag | output | 1 | Watchdog time-out flag |
| wdt_clr | output | 1 | One-cycle watchdog counter clear at halt entry |
| wdt_run | output | 1 | Watchdog counter enable |

## Verification
Some properties are checked on every cycle. These are the flag and clock-enable effects of halt entry and of the clear-watchdog instruction, and the one-cycle gap between the recorded cause and the return of the clock enable. They also cover the one-hot form of the cause and its stability while running, the pairing of the reset strobes with their causes, and the watchdog enable chosen at sleep entry. Other behaviour can only be shown by the bench's scenarios. This includes the three-cycle pin synchronizer latency, the blocking of disabled pins and rising edges, and the priority among sources that arrive in the same cycle.

// File: rtl/pdw_pkg.sv
// Shared types for the power-down sequencer.
// Assumes: one always-on clock domain for all of the block's logic.
package pdw_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } pdw_state_t;

    localparam int CAUSE_W = 4;
    localparam int CZ_RST  = 0;
    localparam int CZ_PIN  = 1;
    localparam int CZ_IRQ  = 2;
    localparam int CZ_WDT  = 3;
endpackage

// File: rtl/pdw_pin_sync.sv
// Port-pin synchronizer and falling-edge finder.
// Each pin passes through SYNC_STAGES flops, followed by one history flop.
// A fall is a synchronized high followed by a synchronized low on a pin whose
// enable bit is set. Assumes: pins idle high, so the reset value is all ones.
module pdw_pin_sync #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins,
    input  logic [NPINS-1:0] enable,
    output logic             fall_any
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [NPINS-1:0] fall_vec;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [CHAIN-1:0] chain;

        // Shift the pin through the synchronizer and history flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[CHAIN-2:0], pins[g]};
        end

        // Mark an enabled high-to-low transition.
        assign fall_vec[g] = enable[g] & chain[CHAIN-1] & ~chain[CHAIN-2];
    end

    assign fall_any = |fall_vec;
endmodule

// File: rtl/pdw_wake_arb.sv
// Fixed-priority wake arbiter: reset, then watchdog, then interrupt, then pin.
// Purely combinational. Assumes: the inputs are already in the clk domain.
module pdw_wake_arb
    import pdw_pkg::*;
(
    input  logic               ext_reset,
    input  logic               wdt_ovf,
    input  logic               irq,
    input  logic               pin_fall,
    output logic [CAUSE_W-1:0] cause,
    output logic               any
);
    // Pick the single highest-priority pending source.
    always_comb begin
        cause = '0;
        if (ext_reset)    cause[CZ_RST] = 1'b1;
        else if (wdt_ovf) cause[CZ_WDT] = 1'b1;
        else if (irq)     cause[CZ_IRQ] = 1'b1;
        else if (pin_fall) cause[CZ_PIN] = 1'b1;
    end

    assign any = |cause;
endmodule

// File: rtl/pdw_seq.sv
// Sleep state machine, status flags and watchdog enable.
// States: RUN, then SLEEP after a halt, then WAKE for one cycle, then RUN.
// Assumes: halt_req and clrwdt_req only arrive while the core runs.
module pdw_seq
    import pdw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic               clrwdt_req,
    input  logic               ext_reset,
    input  logic               wdt_src_sys,
    input  logic               wake_any,
    input  logic [CAUSE_W-1:0] wake_sel,
    output logic               core_clk_en,
    output logic               sleeping,
    output logic [CAUSE_W-1:0] wake_cause,
    output logic               pcsp_rst,
    output logic               full_rst,
    output logic               pdf,
    output logic               to_flag,
    output logic               wdt_clr,
    output logic               wdt_run
);
    pdw_state_t state;

    // Step the sequencer and update flags, strobes and watchdog control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_RUN;
            core_clk_en <= 1'b1;
            wake_cause  <= '0;
            pcsp_rst    <= 1'b0;
            full_rst    <= 1'b0;
            pdf         <= 1'b0;
            to_flag     <= 1'b0;
            wdt_clr     <= 1'b0;
            wdt_run     <= 1'b1;
        end else begin
            pcsp_rst <= 1'b0;
            full_rst <= 1'b0;
            wdt_clr  <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    if (ext_reset) begin
                        full_rst <= 1'b1;
                    end else if (halt_req) begin
                        state       <= ST_SLEEP;
                        core_clk_en <= 1'b0;
                        pdf         <= 1'b1;
                        to_flag     <= 1'b0;
                        wake_cause  <= '0;
                        wdt_clr     <= ~wdt_src_sys;
                        wdt_run     <= ~wdt_src_sys;
                    end else if (clrwdt_req) begin
                        pdf <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (wake_any) begin
                        state      <= ST_WAKE;
                        wake_cause <= wake_sel;
                        if (wake_sel[CZ_WDT]) to_flag <= 1'b1;
                    end
                end
                ST_WAKE: begin
                    state       <= ST_RUN;
                    core_clk_en <= 1'b1;
                    wdt_run     <= 1'b1;
                    pcsp_rst    <= wake_cause[CZ_WDT];
                    full_rst    <= wake_cause[CZ_RST];
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    assign sleeping = (state != ST_RUN);

    p_halt_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && halt_req && !ext_reset)
        |=> (sleeping && !core_clk_en && pdf && !to_flag && wake_cause == '0));

    p_clrwdt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && clrwdt_req && !halt_req && !ext_reset) |=> !pdf);

    p_to_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> wake_cause[CZ_WDT]);

    p_pcsp_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pcsp_rst |-> (core_clk_en && wake_cause[CZ_WDT] && !full_rst));

    p_wake_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> ($past(wake_cause) != '0 && !sleeping));

    p_wdt_ctl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleeping) |-> (wdt_run == !$past(wdt_src_sys) && wdt_clr == wdt_run));

    p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_cause));

    p_cause_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && !(halt_req && !ext_reset)) |=> $stable(wake_cause));

    p_run_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping && ext_reset) |=> (full_rst && !sleeping && core_clk_en));
endmodule

// File: rtl/pdwake_ctrl.sv
// Top of the power-down and wake-up sequencer.
// Joins the pin edge finder, the wake arbiter and the sequencer.
// Assumes: clk never stops, and every input except port_in is synchronous to clk.
module pdwake_ctrl
    import pdw_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic               clrwdt_req,
    input  logic               ext_reset,
    input  logic               irq,
    input  logic               wdt_ovf,
    input  logic               wdt_src_sys,
    input  logic [NPINS-1:0]   port_in,
    input  logic [NPINS-1:0]   wake_enable,
    output logic               core_clk_en,
    output logic               sleeping,
    output logic [CAUSE_W-1:0] wake_cause,
    output logic               pcsp_rst,
    output logic               full_rst,
    output logic               pdf,
    output logic               to_flag,
    output logic               wdt_clr,
    output logic               wdt_run
);
    logic               pin_fall;
    logic [CAUSE_W-1:0] sel;
    logic               any;

    pdw_pin_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (port_in),
        .enable   (wake_enable),
        .fall_any (pin_fall)
    );

    pdw_wake_arb u_arb (
        .ext_reset (ext_reset),
        .wdt_ovf   (wdt_ovf),
        .irq       (irq),
        .pin_fall  (pin_fall),
        .cause     (sel),
        .any       (any)
    );

    pdw_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_req    (halt_req),
        .clrwdt_req  (clrwdt_req),
        .ext_reset   (ext_reset),
        .wdt_src_sys (wdt_src_sys),
        .wake_any    (any),
        .wake_sel    (sel),
        .core_clk_en (core_clk_en),
        .sleeping    (sleeping),
        .wake_cause  (wake_cause),
        .pcsp_rst    (pcsp_rst),
        .full_rst    (full_rst),
        .pdf         (pdf),
        .to_flag     (to_flag),
        .wdt_clr     (wdt_clr),
        .wdt_run     (wdt_run)
    );
endmodule

// File: tb/pdwake_ctrl_test.sv
// Bench for pdwake_ctrl: a vector table of wake scenarios, then directed tests.
module pdwake_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0, clrwdt_req = 1'b0, ext_reset = 1'b0;
    logic       irq = 1'b0, wdt_ovf = 1'b0, wdt_src_sys = 1'b0;
    logic [7:0] port_in = 8'hFF, wake_enable = 8'hFF;
    logic       core_clk_en, sleeping, pcsp_rst, full_rst, pdf, to_flag, wdt_clr, wdt_run;
    logic [3:0] wake_cause;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pdwake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .clrwdt_req(clrwdt_req),
        .ext_reset(ext_reset), .irq(irq), .wdt_ovf(wdt_ovf), .wdt_src_sys(wdt_src_sys),
        .port_in(port_in), .wake_enable(wake_enable), .core_clk_en(core_clk_en),
        .sleeping(sleeping), .wake_cause(wake_cause), .pcsp_rst(pcsp_rst),
        .full_rst(full_rst), .pdf(pdf), .to_flag(to_flag), .wdt_clr(wdt_clr),
        .wdt_run(wdt_run)
    );

    // stim bits: 0 ext_reset, 1 pin, 2 irq, 3 wdt_ovf
    typedef struct packed {
        logic       src_sys;
        logic [3:0] stim;
        logic [2:0] pin;
        logic [3:0] cause;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'b0100, 3'd0, 4'b0100},
        '{1'b0, 4'b1000, 3'd0, 4'b1000},
        '{1'b1, 4'b0001, 3'd0, 4'b0001},
        '{1'b0, 4'b0010, 3'd3, 4'b0010},
        '{1'b1, 4'b0010, 3'd0, 4'b0010},
        '{1'b0, 4'b0010, 3'd7, 4'b0010},
        '{1'b1, 4'b1111, 3'd5, 4'b0001},
        '{1'b0, 4'b1100, 3'd0, 4'b1000},
        '{1'b0, 4'b0110, 3'd2, 4'b0100}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_halt(input logic src);
        wdt_src_sys = src;
        halt_req = 1'b1;
        tick(1);
        halt_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 sleeping", sleeping, 0);
        chk("R1 pdf", pdf, 0);
        chk("R1 to", to_flag, 0);
        chk("R1 cause", wake_cause, 0);
        chk("R1 strobes", {pcsp_rst, full_rst, wdt_clr}, 0);
        chk("R1 wdt_run", wdt_run, 1);
        rst_n = 1'b1;
        tick(4);

        // Table-driven wake scenarios (R2, R4, R6-R12)
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int lat;
            v = VECS[i];
            do_halt(v.src_sys);
            chk("R2 sleeping", sleeping, 1);
            chk("R2 clk_en", core_clk_en, 0);
            chk("R2 pdf", pdf, 1);
            chk("R2 to", to_flag, 0);
            chk("R2 cause cleared", wake_cause, 0);
            chk("R11 wdt_clr", wdt_clr, !v.src_sys);
            chk("R11 wdt_run", wdt_run, !v.src_sys);
            ext_reset = v.stim[0];
            irq = v.stim[2];
            wdt_ovf = v.stim[3];
            if (v.stim[1]) port_in[v.pin] = 1'b0;
            lat = (v.stim[0] | v.stim[2] | v.stim[3]) ? 1 : 3;
            tick(lat);
            ext_reset = 1'b0; irq = 1'b0; wdt_ovf = 1'b0;
            chk("R9 cause", wake_cause, v.cause);
            chk("R10 still gated", core_clk_en, 0);
            chk("R7 to", to_flag, v.cause[3]);
            chk("R11 wdt_clr once", wdt_clr, 0);
            tick(1);
            chk("R10 clk_en back", core_clk_en, 1);
            chk("R10 awake", sleeping, 0);
            chk("R7 pcsp_rst", pcsp_rst, v.cause[3]);
            chk("R8 full_rst", full_rst, v.cause[0]);
            chk("R7 pdf kept", pdf, 1);
            chk("R11 wdt_run back", wdt_run, 1);
            tick(1);
            chk("R8 strobe one cycle", {pcsp_rst, full_rst}, 0);
            port_in = 8'hFF;
            tick(4);
            chk("R12 cause held", wake_cause, v.cause);
        end

        // R3: clear-watchdog clears pdf while running
        chk("R3 pdf before", pdf, 1);
        clrwdt_req = 1'b1;
        tick(1);
        clrwdt_req = 1'b0;
        chk("R3 pdf cleared", pdf, 0);

        // R13: external reset while running
        ext_reset = 1'b1;
        tick(1);
        ext_reset = 1'b0;
        chk("R13 full_rst", full_rst, 1);
        chk("R13 awake", sleeping, 0);
        tick(1);
        chk("R13 one cycle", full_rst, 0);

        // R5: disabled pin and rising edges do not wake
        wake_enable = 8'h02;
        port_in[1] = 1'b0;
        tick(5);
        do_halt(1'b0);
        port_in[4] = 1'b0;
        port_in[1] = 1'b1;
        tick(6);
        chk("R5 still asleep", sleeping, 1);
        chk("R5 cause zero", wake_cause, 0);
        chk("R5 clk gated", core_clk_en, 0);
        port_in[4] = 1'b1;
        tick(6);
        chk("R5 rising ignored", sleeping, 1);
        // R4: the enabled pin 1 now falls and wakes the core
        port_in[1] = 1'b0;
        tick(3);
        chk("R4 cause pin", wake_cause, 4'b0010);
        tick(1);
        chk("R4 awake", sleeping, 0);
        chk("R4 no strobe", {pcsp_rst, full_rst}, 0);
        port_in = 8'hFF;
        tick(4);

        // R8: external reset wake keeps the flags
        do_halt(1'b0);
        ext_reset = 1'b1;
        tick(1);
        ext_reset = 1'b0;
        chk("R8 cause", wake_cause, 4'b0001);
        chk("R8 pdf kept", pdf, 1);
        chk("R8 to kept", to_flag, 0);
        tick(1);
        chk("R8 full_rst", full_rst, 1);

        // R1: reset asserted again returns the initial state
        rst_n = 1'b0;
        tick(1);
        chk("R1 re-reset pdf", pdf, 0);
        chk("R1 re-reset cause", wake_cause, 0);
        rst_n = 1'b1;
        tick(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule